// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the column side of a synchronous DRAM bank, as seen from inside the device. A registered READ or WRITE command carries a starting column. From that column the engine produces the column address of every beat of the burst. Write beats are stored in an internal array of 16-bit words. Read beats leave on a registered DQ output, together with an output-enable, after the programmed CAS latency.

A 5-bit mode word sets four things: the burst length, the address order (sequential or interleaved), the CAS latency (2 or 3) and a single-write flag. When the single-write flag is set, every WRITE touches exactly one column, while READs keep the programmed length and order.

The clock-enable input is registered on every rising edge. When it was low at one edge, the following edge is suspended. On a suspended edge the engine ignores commands and write data, holds DQ and its enable, and does not advance the beat counter. A new command on an active edge cuts short any burst in progress.

Top module: `sdram_burst_engine`

## Requirements
- R1: While and after synchronous reset, with no command given, `dq_oe` is 0.
- R2: A WRITE stores its first beat from `wdata` at the command edge, then one beat per active edge at the following burst columns, until the burst length is reached.
- R3: With `mode_word[3]`=0 (CAS latency 2), a beat read at active edge k is on `dq_out` with `dq_oe`=1 after active edge k+2. Beats follow one per active edge. `dq_oe` falls one active edge after the last beat.
- R4: With `mode_word[3]`=1 (CAS latency 3), a beat read at active edge k is on `dq_out` after active edge k+3.
- R5: With `mode_word[2]`=1, beat i uses the low column bits (start XOR i). With `mode_word[2]`=0, it uses (start + i), and the sum wraps within the block.
- R6: `mode_word[1:0]` codes 0/1/2/3 give burst lengths 1/2/4/8. Every beat stays inside the aligned block of that length that holds the start column.
- R7: With `mode_word[4]`=1, a WRITE stores only one column. READs still use the programmed length and order.
- R8: If `cke` was low at the previous rising edge, the current edge is suspended: a command and any write data at that edge are ignored.
- R9: On a suspended edge, `dq_out`, `dq_oe` and the beat counter hold their values. Operation resumes on the first edge after `cke` is sampled high again.
- R10: A READ or WRITE on an active edge ends the burst in progress and starts the new burst at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, registered every edge |
| cmd_valid | input | 1 | Command present this edge |
| cmd_we | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | 8 | Starting column |
| wdata | input | 16 | Write beat data |
| mode_word | input | 5 | [1:0] length code, [2] interleave, [3] CAS latency 3, [4] single write |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data valid / output drive enable |

## Verification
Two events can fall on the same edge: a clock suspension and a beat that is due, either a read beat that should reach DQ or a write beat that should be stored. Random phases lower `cke` on about a quarter of the edges while random bursts are running. Directed cases drop `cke` in the middle of a write burst, while read data is on DQ, and one edge before a new command. A cycle model in the bench counts only active edges. From the mode and the start column it predicts which column each beat uses and the active edge on which each read beat appears. DQ and its enable are compared with that prediction on every clock. A write beat that was wrongly accepted, or wrongly dropped, shows up later as a read mismatch.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef struct packed {
    logic       single_wr;
    logic       cl3;
    logic       intl;
    logic [1:0] blc;
  } mode_t;
endpackage

// File: rtl/sdb_burst_ctrl.sv
module sdb_burst_ctrl
  import sdb_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cmd_valid,
  input  logic             cmd_we,
  input  logic [COL_W-1:0] cmd_col,
  input  mode_t            mode,
  output logic             issue,
  output logic             issue_we,
  output logic [COL_W-1:0] issue_col,
  output logic             cl3_lat
);
  logic             busy, we_lat, intl_lat, single_lat;
  logic [1:0]       blc_lat, blc_eff;
  logic [IDX_W-1:0] idx, len_mask;
  logic [COL_W-1:0] base, blk_mask;
  logic             start;

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] b,
      input logic [IDX_W-1:0] i, input logic [1:0] c, input logic il);
    logic [COL_W-1:0] m, lo;
    m  = COL_W'((1 << c) - 1);
    lo = il ? (b ^ COL_W'(i)) : (b + COL_W'(i));
    return (b & ~m) | (lo & m);
  endfunction

  assign start     = en && cmd_valid;
  assign blc_eff   = (cmd_we && mode.single_wr) ? 2'd0 : mode.blc;
  assign len_mask  = IDX_W'((1 << blc_lat) - 1);
  assign blk_mask  = COL_W'((1 << blc_lat) - 1);
  assign issue     = start || (en && busy);
  assign issue_we  = start ? cmd_we : we_lat;
  assign issue_col = start ? cmd_col : beat_col(base, idx, blc_lat, intl_lat);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; idx <= '0; base <= '0; we_lat <= 1'b0;
      blc_lat <= 2'd0; intl_lat <= 1'b0; cl3_lat <= 1'b0; single_lat <= 1'b0;
    end else if (en) begin
      if (start) begin
        base       <= cmd_col;
        we_lat     <= cmd_we;
        blc_lat    <= blc_eff;
        intl_lat   <= mode.intl;
        cl3_lat    <= mode.cl3;
        single_lat <= mode.single_wr;
        busy       <= (blc_eff != 2'd0);
        idx        <= IDX_W'(1);
      end else if (busy) begin
        idx <= idx + IDX_W'(1);
        if (idx == len_mask) busy <= 1'b0;
      end
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx != '0) && (idx <= len_mask));
  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && we_lat) |-> !single_lat);
  // R9
  idx_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(idx) && $stable(busy) && $stable(base));
  // R6
  col_block_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !start) |-> (((issue_col ^ base) & ~blk_mask) == '0));
endmodule

// File: rtl/sdb_read_pipe.sv
module sdb_read_pipe #(
  parameter int DATA_W = 16,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_v,
  input  logic [DATA_W-1:0] in_d,
  input  logic              cl3,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int NST = MAX_CL - 1;
  logic              st_v [NST];
  logic [DATA_W-1:0] st_d [NST];
  logic              tap_v;
  logic [DATA_W-1:0] tap_d;
  int                tap;

  assign tap = cl3 ? 1 : 0;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        st_v[g] <= 1'b0;
        st_d[g] <= '0;
      end else if (en) begin
        st_v[g] <= (g == 0) ? in_v : st_v[(g == 0) ? 0 : g - 1];
        st_d[g] <= (g == 0) ? in_d : st_d[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_comb begin
    tap_v = 1'b0;
    tap_d = '0;
    for (int i = 0; i < NST; i++) begin
      if (i == tap) begin
        tap_v = st_v[i];
        tap_d = st_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else if (en) begin
      dq_out <= tap_d;
      dq_oe  <= tap_v;
    end
  end

  // R3
  oe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tap_v) |=> !dq_oe);
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdb_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DATA_W-1:0] wdata,
  input  logic [4:0]        mode_word,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int COLS = 1 << COL_W;

  logic              cke_q;
  logic              issue, issue_we, cl3_lat;
  logic [COL_W-1:0]  issue_col;
  logic [DATA_W-1:0] mem [COLS];
  logic [DATA_W-1:0] rd_q;
  logic              rd_v;
  mode_t             mode;

  assign mode = mode_t'(mode_word);

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  sdb_burst_ctrl #(.COL_W(COL_W), .IDX_W(3)) i_ctrl (
    .clk(clk), .rst(rst), .en(cke_q),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_col(cmd_col), .mode(mode),
    .issue(issue), .issue_we(issue_we), .issue_col(issue_col), .cl3_lat(cl3_lat)
  );

  always_ff @(posedge clk) begin
    if (cke_q && issue && issue_we) mem[issue_col] <= wdata;
    if (cke_q) rd_q <= mem[issue_col];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_v <= 1'b0;
    else if (cke_q) rd_v <= issue && !issue_we;
  end

  sdb_read_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) i_pipe (
    .clk(clk), .rst(rst), .en(cke_q), .in_v(rd_v), .in_d(rd_q),
    .cl3(cl3_lat), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R9
  dq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> $stable(dq_out) && $stable(dq_oe));
  // R1
  reset_oe_chk: assert property (@(posedge clk)
    rst |=> !dq_oe);
endmodule

// File: tb/test_sdram_burst_engine.sv
module test_sdram_burst_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cmd_valid = 1'b0, cmd_we = 1'b0;
  logic [7:0]  cmd_col = '0;
  logic [15:0] wdata = '0;
  logic [4:0]  mode_word = '0;
  logic [15:0] dq_out;
  logic        dq_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // bench model state
  bit [15:0] m_mem [256];
  bit [15:0] ring_d [16];
  bit        ring_v [16];
  bit        m_cke_prev = 1, m_busy = 0, m_we = 0, m_intl = 0;
  int        m_k = 0, m_idx = 0, m_len = 1, m_cl = 2;
  bit [7:0]  m_base = 0;
  bit        e_oe = 0;
  bit [15:0] e_dq = 0;

  always #10 clk = ~clk;

  sdram_burst_engine i_sdram_burst_engine (
    .clk(clk), .rst(rst), .cke(cke), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
    .cmd_col(cmd_col), .wdata(wdata), .mode_word(mode_word),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic bit [7:0] exp_col(bit [7:0] b, int i, int len, bit il);
    int off, start;
    start = b % len;
    off   = il ? (start ^ i) : ((start + i) % len);
    return 8'(b - start + off);
  endfunction

  task automatic do_beat(int i);
    bit [7:0] a;
    a = exp_col(m_base, i, m_len, m_intl);
    if (m_we) m_mem[a] = wdata;
    else begin
      ring_v[(m_k + m_cl) % 16] = 1;
      ring_d[(m_k + m_cl) % 16] = m_mem[a];
    end
  endtask

  task automatic model_edge();
    bit en;
    en = m_cke_prev;
    m_cke_prev = cke;
    if (!en) return;
    m_k++;
    if (cmd_valid) begin
      m_base = cmd_col; m_we = cmd_we; m_intl = mode_word[2];
      m_cl   = mode_word[3] ? 3 : 2;
      m_len  = (cmd_we && mode_word[4]) ? 1 : (1 << mode_word[1:0]);
      do_beat(0);
      m_idx = 1; m_busy = (m_len > 1);
    end else if (m_busy) begin
      do_beat(m_idx);
      m_idx++;
      if (m_idx == m_len) m_busy = 0;
    end
    e_oe = ring_v[m_k % 16];
    e_dq = ring_d[m_k % 16];
    ring_v[m_k % 16] = 0;
  endtask

  task automatic compare();
    n_chk++;
    if (dq_oe !== e_oe || (e_oe && dq_out !== e_dq)) begin
      n_bad++;
      $display("FAIL %s: got oe=%0b dq=%h, expected oe=%0b dq=%h at active edge %0d",
               tag, dq_oe, dq_out, e_oe, e_dq, m_k);
    end
  endtask

  task automatic step(bit c, bit v, bit w, bit [7:0] col, bit [15:0] d);
    cke = c; cmd_valid = v; cmd_we = w; cmd_col = col; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, 16'h0000);
  endtask

  task automatic wr(bit [7:0] col, bit [15:0] d); step(1, 1, 1, col, d); endtask
  task automatic rd(bit [7:0] col); step(1, 1, 0, col, 16'h0000); endtask

  initial begin
    void'($urandom(32'd7319));
    for (int i = 0; i < 16; i++) ring_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1: output enable low under reset
    n_chk++;
    if (dq_oe !== 1'b0) begin n_bad++; $display("FAIL R1: oe=%0b expected 0", dq_oe); end
    rst = 1'b0;
    tag = "R1"; idle(2);

    // R2: fill every column with BL8 sequential writes
    tag = "R2"; mode_word = 5'b00011;
    for (int b = 0; b < 32; b++) begin
      wr(8'(b * 8), 16'(b * 8 + 16'h1000));
      for (int i = 1; i < 8; i++) step(1, 0, 0, 8'h00, 16'($urandom));
    end
    idle(2);

    // R3: BL4 sequential, CAS 2, start mid-block so the sum wraps
    tag = "R3"; mode_word = 5'b00010;
    rd(8'h0E); idle(6);
    // R4: CAS 3
    tag = "R4"; mode_word = 5'b01010;
    rd(8'h23); idle(7);
    // R5: BL8 interleaved, CAS 3
    tag = "R5"; mode_word = 5'b01111;
    rd(8'h15); idle(11);
    // R6: lengths 1 and 2
    tag = "R6"; mode_word = 5'b00001;
    wr(8'h31, 16'hAAAA); step(1, 0, 0, 8'h00, 16'hBBBB); idle(1);
    rd(8'h31); idle(4);
    mode_word = 5'b00000;
    wr(8'h47, 16'hC0DE); rd(8'h47); idle(4);
    // R7: single write under BL4, then a BL4 read
    tag = "R7"; mode_word = 5'b10010;
    wr(8'h52, 16'h1111); step(1, 0, 0, 8'h00, 16'h2222);
    step(1, 0, 0, 8'h00, 16'h3333); step(1, 0, 0, 8'h00, 16'h4444);
    rd(8'h50); idle(6);
    // R8: suspend mid-write burst; the suspended beat data is ignored
    tag = "R8"; mode_word = 5'b00010;
    wr(8'h60, 16'hA000); step(0, 0, 0, 8'h00, 16'hA001);
    step(1, 0, 0, 8'h00, 16'hDEAD); step(1, 0, 0, 8'h00, 16'hA002);
    step(1, 0, 0, 8'h00, 16'hA003); idle(2);
    // R8: command on a suspended edge is dropped
    step(0, 0, 0, 8'h00, 16'h0000); wr(8'h70, 16'hBAD0); idle(5);
    rd(8'h70); idle(6);
    rd(8'h60); idle(6);
    // R9: suspend while read data is on DQ
    tag = "R9";
    rd(8'h60); step(1, 0, 0, 8'h00, 16'h0000); step(0, 0, 0, 8'h00, 16'h0000);
    step(0, 0, 0, 8'h00, 16'h0000); step(1, 0, 0, 8'h00, 16'h0000); idle(6);
    // R10: new command truncates a BL8 read
    tag = "R10"; mode_word = 5'b00011;
    rd(8'h80); idle(2); rd(8'h90); idle(12);
    wr(8'hA0, 16'h5A5A); step(1, 0, 0, 8'h00, 16'h5A5B); wr(8'hB3, 16'h6A6A);
    idle(8); rd(8'hA0); idle(10); rd(8'hB0); idle(10);

    // random phases with suspension
    tag = "R9";
    for (int s = 0; s < 30; s++) begin
      mode_word = 5'($urandom);
      for (int i = 0; i < 40; i++)
        step(($urandom % 4) != 0, ($urandom % 5) == 0, $urandom % 2,
             8'($urandom), 16'($urandom));
      idle(14);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule